// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

This block moves single data words between two unrelated clock domains, side A and side B, through two one-word mailboxes. Mailbox 1 takes a word written on side A and delivers it to side B. Mailbox 2 carries words from side B to side A. Each side drives a chip select (active low), a transfer enable, a mailbox select and a direction bit. A side takes part in a mailbox transfer only when all four qualify the access.

Each mailbox has an occupancy indication, called `clear`, in both domains. `clear` is high while the mailbox is empty and low while it holds a word that has not been read. An accepted write pulls the writer's copy low at once. From then on the writer cannot overwrite the word. The word becomes visible to the reader after synchronization. When the reader reads, its own copy goes high at once. The writer's copy follows after synchronization. Occupancy is tracked with toggle events that cross between the domains through multi-flop synchronizers. The stored word stays frozen while it is pending, so it needs no synchronization of its own.

Top module: `xclk_mailbox`

## Requirements
- R1: While both resets are held, and after they are released, all four `clear` outputs are 1 and both read data outputs are 0 until the first accepted transfer.
- R2: A side performs a mailbox write only on a rising edge of its clock where cs_n=0, en=1, mbox=1 and dir=1 (dir=1 means write). Any other combination leaves the mailbox and both of its `clear` copies unchanged.
- R3: An accepted write stores the word and drives the writer-side `clear` of that mailbox to 0 right after the writing edge.
- R4: While the writer-side `clear` is 0, write attempts to that mailbox are ignored, and the word later read is the first one written.
- R5: After an accepted write, the reader-side `clear` of that mailbox falls to 0 within SYNC_STAGES+2 reader clock edges.
- R6: A reader edge with cs_n=0, en=1, mbox=1 and dir=0 while the reader-side `clear` is 0 loads the stored word into that side's read data output and drives the reader-side `clear` to 1 right after the edge.
- R7: After a read, the writer-side `clear` returns to 1 within SYNC_STAGES+3 writer clock edges.
- R8: A read attempt while the reader-side `clear` is 1, or any non-qualifying access on the reader side, leaves the read data output and the mailbox state unchanged.
- R9: The two mailboxes are independent. Transfers in both directions may be in flight at the same time, and each delivers its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a | input | 1 | Side A synchronous reset, active high |
| a_cs_n | input | 1 | Side A chip select, active low |
| a_en | input | 1 | Side A transfer enable |
| a_mbox | input | 1 | Side A mailbox select |
| a_dir | input | 1 | Side A direction, 1 = write mailbox 1, 0 = read mailbox 2 |
| a_wdata | input | DATA_W | Side A write word |
| a_rdata | output | DATA_W | Last word read from mailbox 2 |
| a_mb1_clear | output | 1 | Mailbox 1 empty, side A copy |
| a_mb2_clear | output | 1 | Mailbox 2 empty, side A copy |
| clk_b | input | 1 | Side B clock |
| rst_b | input | 1 | Side B synchronous reset, active high |
| b_cs_n | input | 1 | Side B chip select, active low |
| b_en | input | 1 | Side B transfer enable |
| b_mbox | input | 1 | Side B mailbox select |
| b_dir | input | 1 | Side B direction, 1 = write mailbox 2, 0 = read mailbox 1 |
| b_wdata | input | DATA_W | Side B write word |
| b_rdata | output | DATA_W | Last word read from mailbox 1 |
| b_mb1_clear | output | 1 | Mailbox 1 empty, side B copy |
| b_mb2_clear | output | 1 | Mailbox 2 empty, side B copy |

## Verification
The bench builds the block with DATA_W=36 and SYNC_STAGES=2. Side A runs with a 10-unit period and side B with a 14-unit period, so the two edges drift against each other. Toggle events therefore meet the synchronizers at many phase offsets. The full 36-bit width brings upper-bit corruption of the stored word within reach. Two synchronizer stages keep the R5 and R7 latency bounds short enough to check exactly.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef struct packed {
    logic cs_n;
    logic en;
    logic mbox;
    logic dir;
  } port_req_t;

  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[gi] <= 1'b0;
          else     stg_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[gi] <= 1'b0;
          else     stg_q[gi] <= stg_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xmb_port_decode.sv
module xmb_port_decode
  import xmb_pkg::*;
(
  input  port_req_t req,
  output logic      wr_hit,
  output logic      rd_hit
);
  logic qualified;

  always_comb begin
    qualified = !req.cs_n && req.en && req.mbox;
    wr_hit    = qualified && req.dir;
    rd_hit    = qualified && !req.dir;
  end
endmodule

// File: rtl/xmb_channel.sv
module xmb_channel #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              w_clear,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_hit,
  output logic [DATA_W-1:0] rdata,
  output logic              r_clear
);
  logic              set_tog_q;
  logic              clr_tog_q;
  logic              clr_in_w;
  logic              set_in_r;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_take;
  logic              rd_take;

  // writer domain
  xmb_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(wclk), .rst(wrst), .d(clr_tog_q), .q(clr_in_w)
  );

  assign w_clear = ~(set_tog_q ^ clr_in_w);
  assign wr_take = wr_hit && w_clear;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      set_tog_q <= 1'b0;
      word_q    <= '0;
    end else if (wr_take) begin
      set_tog_q <= ~set_tog_q;
      word_q    <= wdata;
    end
  end

  // reader domain
  xmb_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk(rclk), .rst(rrst), .d(set_tog_q), .q(set_in_r)
  );

  assign r_clear = ~(set_in_r ^ clr_tog_q);
  assign rd_take = rd_hit && !r_clear;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      clr_tog_q <= 1'b0;
      rdata_q   <= '0;
    end else if (rd_take) begin
      clr_tog_q <= ~clr_tog_q;
      rdata_q   <= word_q;
    end
  end

  assign rdata = rdata_q;

  AST_RESET_WCLEAR: assert property (@(posedge wclk) wrst |=> w_clear)
    else $error("writer clear low after reset"); // R1
  AST_WRITE_SETS: assert property (@(posedge wclk) disable iff (wrst)
    (wr_hit && w_clear) |=> !w_clear)
    else $error("accepted write left clear high"); // R3
  AST_WRITE_BLOCKED: assert property (@(posedge wclk) disable iff (wrst)
    !w_clear |=> $stable(word_q))
    else $error("pending word changed"); // R4
  AST_READ_CLEARS: assert property (@(posedge rclk) disable iff (rrst)
    (rd_hit && !r_clear) |=> r_clear)
    else $error("read left reader clear low"); // R6
  AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (rrst)
    !(rd_hit && !r_clear) |=> $stable(rdata_q))
    else $error("read data moved without a read"); // R8
endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
  import xmb_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              a_cs_n,
  input  logic              a_en,
  input  logic              a_mbox,
  input  logic              a_dir,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_mb1_clear,
  output logic              a_mb2_clear,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              b_cs_n,
  input  logic              b_en,
  input  logic              b_mbox,
  input  logic              b_dir,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_mb1_clear,
  output logic              b_mb2_clear
);
  // side index s writes channel s and reads channel 1-s
  logic              clk_v   [NUM_SIDES];
  logic              rst_v   [NUM_SIDES];
  port_req_t         req_v   [NUM_SIDES];
  logic [DATA_W-1:0] wdata_v [NUM_SIDES];
  logic              wr_hit_v[NUM_SIDES];
  logic              rd_hit_v[NUM_SIDES];
  logic [DATA_W-1:0] rdata_v [NUM_SIDES];
  logic              wclr_v  [NUM_SIDES];
  logic              rclr_v  [NUM_SIDES];

  assign clk_v[0]   = clk_a;
  assign clk_v[1]   = clk_b;
  assign rst_v[0]   = rst_a;
  assign rst_v[1]   = rst_b;
  assign req_v[0]   = '{cs_n: a_cs_n, en: a_en, mbox: a_mbox, dir: a_dir};
  assign req_v[1]   = '{cs_n: b_cs_n, en: b_en, mbox: b_mbox, dir: b_dir};
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SIDES; gs++) begin : g_side
      xmb_port_decode u_dec (
        .req(req_v[gs]), .wr_hit(wr_hit_v[gs]), .rd_hit(rd_hit_v[gs])
      );

      xmb_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
        .wclk   (clk_v[gs]),
        .wrst   (rst_v[gs]),
        .wr_hit (wr_hit_v[gs]),
        .wdata  (wdata_v[gs]),
        .w_clear(wclr_v[gs]),
        .rclk   (clk_v[1-gs]),
        .rrst   (rst_v[1-gs]),
        .rd_hit (rd_hit_v[1-gs]),
        .rdata  (rdata_v[gs]),
        .r_clear(rclr_v[gs])
      );
    end
  endgenerate

  assign a_mb1_clear = wclr_v[0];
  assign b_mb1_clear = rclr_v[0];
  assign b_mb2_clear = wclr_v[1];
  assign a_mb2_clear = rclr_v[1];
  assign b_rdata     = rdata_v[0];
  assign a_rdata     = rdata_v[1];
endmodule

// File: tb/tb_xclk_mailbox.sv
module tb_xclk_mailbox;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W            = 36;
  localparam int SYNC         = 2;
  localparam int ITERS        = 40;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic a_cs_n = 1'b1, a_en = 1'b0, a_mbox = 1'b0, a_dir = 1'b0;
  logic b_cs_n = 1'b1, b_en = 1'b0, b_mbox = 1'b0, b_dir = 1'b0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_mb1_clear, a_mb2_clear, b_mb1_clear, b_mb2_clear;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] exp_word [2];
  logic [W-1:0] last_rd  [2];

  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  xclk_mailbox #(.DATA_W(W), .SYNC_STAGES(SYNC)) dut (.*);

  function automatic logic is_wr(logic cs_n, logic en, logic mb, logic dir);
    return !cs_n && en && mb && dir;
  endfunction
  function automatic logic is_rd(logic cs_n, logic en, logic mb, logic dir);
    return !cs_n && en && mb && !dir;
  endfunction
  function automatic logic wflag(int ch);
    return (ch == 0) ? a_mb1_clear : b_mb2_clear;
  endfunction
  function automatic logic rflag(int ch);
    return (ch == 0) ? b_mb1_clear : a_mb2_clear;
  endfunction
  function automatic logic [W-1:0] rword(int ch);
    return (ch == 0) ? b_rdata : a_rdata;
  endfunction
  function automatic logic [W-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic side_op(input int s, input logic cs_n, input logic en,
                         input logic mb, input logic dir, input logic [W-1:0] d);
    if (s == 0) begin
      @(negedge clk_a);
      a_cs_n = cs_n; a_en = en; a_mbox = mb; a_dir = dir; a_wdata = d;
      @(negedge clk_a);
      a_en = 1'b0; a_cs_n = 1'b1;
    end else begin
      @(negedge clk_b);
      b_cs_n = cs_n; b_en = en; b_mbox = mb; b_dir = dir; b_wdata = d;
      @(negedge clk_b);
      b_en = 1'b0; b_cs_n = 1'b1;
    end
  endtask

  task automatic wait_edges(input int s);
    if (s == 0) @(negedge clk_a);
    else        @(negedge clk_b);
  endtask

  task automatic wait_reader(input int ch, input logic want, input int maxe, input string req);
    for (int k = 0; k < maxe && rflag(ch) != want; k++) wait_edges(1 - ch);
    check(rflag(ch) == want, req, W'(rflag(ch)), W'(want));
  endtask

  task automatic wait_writer(input int ch, input logic want, input int maxe, input string req);
    for (int k = 0; k < maxe && wflag(ch) != want; k++) wait_edges(ch);
    check(wflag(ch) == want, req, W'(wflag(ch)), W'(want));
  endtask

  task automatic do_read(input int ch);
    side_op(1 - ch, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    last_rd[ch] = exp_word[ch];
    check(rword(ch) == exp_word[ch], "R6/R4 read word", rword(ch), exp_word[ch]);
    check(rflag(ch) == 1'b1, "R6 reader clear high", W'(rflag(ch)), W'(1));
  endtask

  task automatic transfer(input int ch);
    logic cs_n, en, mb, hit;
    logic [W-1:0] d;
    cs_n = ($urandom % 4) == 0;
    en   = ($urandom % 4) != 0;
    mb   = ($urandom % 4) != 0;
    d    = rnd_word();
    hit  = is_wr(cs_n, en, mb, 1'b1);
    side_op(ch, cs_n, en, mb, 1'b1, d);
    if (hit) exp_word[ch] = d;
    check(wflag(ch) == !hit, "R2/R3 writer clear after attempt", W'(wflag(ch)), W'(!hit));
    check(rword(ch) == last_rd[ch], "R2 read data untouched", rword(ch), last_rd[ch]);
    if (!hit) begin
      d = rnd_word();
      side_op(ch, 1'b0, 1'b1, 1'b1, 1'b1, d);
      exp_word[ch] = d;
      check(wflag(ch) == 1'b0, "R3 writer clear low", W'(wflag(ch)), W'(0));
    end
    side_op(ch, 1'b0, 1'b1, 1'b1, 1'b1, ~exp_word[ch]);
    check(wflag(ch) == 1'b0, "R4 blocked write keeps clear low", W'(wflag(ch)), W'(0));
    wait_reader(ch, 1'b0, SYNC + 2, "R5 reader clear falls");
    cs_n = ($urandom % 4) == 0;
    en   = ($urandom % 4) != 0;
    mb   = ($urandom % 4) != 0;
    if (is_rd(cs_n, en, mb, 1'b0)) begin
      do_read(ch);
    end else begin
      side_op(1 - ch, cs_n, en, mb, 1'b0, '0);
      check(rword(ch) == last_rd[ch], "R8 non-qualifying read data", rword(ch), last_rd[ch]);
      check(rflag(ch) == 1'b0, "R8 non-qualifying read clear", W'(rflag(ch)), W'(0));
      do_read(ch);
    end
    side_op(1 - ch, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    check(rword(ch) == last_rd[ch], "R8 empty read keeps data", rword(ch), last_rd[ch]);
    check(rflag(ch) == 1'b1, "R8 empty read keeps clear", W'(rflag(ch)), W'(1));
    wait_writer(ch, 1'b1, SYNC + 3, "R7 writer clear returns");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    exp_word[0] = '0; exp_word[1] = '0;
    last_rd[0]  = '0; last_rd[1]  = '0;
    repeat (6) @(negedge clk_b);
    // R1: state while reset is held
    check(a_mb1_clear && a_mb2_clear && b_mb1_clear && b_mb2_clear,
          "R1 clear during reset", W'({a_mb1_clear, a_mb2_clear, b_mb1_clear, b_mb2_clear}), W'(4'hf));
    rst_a = 1'b0;
    rst_b = 1'b0;
    repeat (3) @(negedge clk_b);
    check(a_mb1_clear && a_mb2_clear && b_mb1_clear && b_mb2_clear,
          "R1 clear after reset", W'({a_mb1_clear, a_mb2_clear, b_mb1_clear, b_mb2_clear}), W'(4'hf));
    check(a_rdata == '0, "R1 a_rdata zero", a_rdata, '0);
    check(b_rdata == '0, "R1 b_rdata zero", b_rdata, '0);

    // R8: read of empty mailboxes does nothing
    side_op(1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    check(b_rdata == '0 && b_mb1_clear, "R8 empty read side B", b_rdata, '0);

    // directed all-ones and all-zeros corner words
    side_op(0, 1'b0, 1'b1, 1'b1, 1'b1, '1);
    exp_word[0] = '1;
    check(a_mb1_clear == 1'b0, "R3 directed write", W'(a_mb1_clear), W'(0));
    side_op(0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    wait_reader(0, 1'b0, SYNC + 2, "R5 directed");
    do_read(0);
    wait_writer(0, 1'b1, SYNC + 3, "R7 directed");

    // R9: both directions in flight together
    fork
      side_op(0, 1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789);
      side_op(1, 1'b0, 1'b1, 1'b1, 1'b1, 36'hA_BCDE_F012);
    join
    exp_word[0] = 36'h1_2345_6789;
    exp_word[1] = 36'hA_BCDE_F012;
    wait_reader(0, 1'b0, SYNC + 3, "R9 mb1 pending");
    wait_reader(1, 1'b0, SYNC + 3, "R9 mb2 pending");
    fork
      side_op(1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
      side_op(0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    join
    last_rd[0] = exp_word[0];
    last_rd[1] = exp_word[1];
    check(b_rdata == exp_word[0], "R9 mb1 word", b_rdata, exp_word[0]);
    check(a_rdata == exp_word[1], "R9 mb2 word", a_rdata, exp_word[1]);
    wait_writer(0, 1'b1, SYNC + 3, "R9 mb1 released");
    wait_writer(1, 1'b1, SYNC + 3, "R9 mb2 released");

    for (int it = 0; it < ITERS; it++) begin
      transfer(it % 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule